// File: doc/BRIEF.md
# Dual-Clock Parallel-Load Shift Register

This block is an eight-stage shift register with two ways of filling it. While the mode input is low, every stage copies its own parallel input on each system clock cycle. While the mode input is high, the contents move one stage toward the output on each rising edge of a combined clock. The last stage drives a serial output and also an inverted copy of that output.

The combined clock is the OR of two clock inputs. Either input can serve as the clock while the other is held low. Holding either input high blocks all edges on the other, so the second input works as an inhibit. All inputs are sampled by a free-running system clock. The two clock inputs pass through one register stage, and the rising edge of their OR is detected internally. A shift therefore takes effect on the second system clock edge after a clock input is first sampled high.

The parallel inputs, the serial input and the outputs are plain level pins with no handshake. The register is always ready. Parallel data is taken on every cycle while a load is active, and serial data is taken at the edge where a shift happens. There is no back-pressure: the user paces the register only through the mode pin and the two clock inputs.

Top module: `dual_clk_shreg`

## Requirements
- R1: While `shift_load_n` is 0, every stage takes its bit of `par_in` on each system clock edge, regardless of `clk_a` and `clk_b`. Stage A is bit 0 and stage H is bit 7.
- R2: With `shift_load_n` at 1 and `clk_b` low, a rising edge of `clk_a` shifts the register once. The shift takes effect on the second system clock edge after `clk_a` is first sampled high.
- R3: With `shift_load_n` at 1 and `clk_a` low, a rising edge of `clk_b` shifts the register once, with the same timing as R2.
- R4: On a shift, stage A takes `ser_in` and each other stage takes the stage before it (A to B, and so on up to G to H). The old value of stage H is lost.
- R5: While one clock input is held high, edges on the other clock input do not shift the register. Releasing the held input does not shift it either.
- R6: With `shift_load_n` at 1 and no rising edge of the combined clock, the contents stay the same, whatever `par_in` and `ser_in` do.
- R7: `q_ser` equals stage H and `q_ser_n` equals its inverse.
- R8: Each rising edge of the combined clock causes exactly one shift, however long the clock stays high. Rising edges on both clock inputs in the same cycle count as one shift.
- R9: A combined-clock rising edge that happens while a load is active causes no shift, either during the load or after it ends.
- R10: An active-low synchronous reset `rst_n` clears all stages, so `q_ser` is 0 and `q_ser_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Synchronous reset, active low |
| shift_load_n | input | 1 | 0 = parallel load, 1 = serial shift |
| clk_a | input | 1 | First clock input, combined with clk_b by OR |
| clk_b | input | 1 | Second clock input, combined with clk_a by OR |
| ser_in | input | 1 | Serial data into stage A |
| par_in | input | 8 | Parallel data, bit 0 = stage A, bit 7 = stage H |
| q_ser | output | 1 | Stage H |
| q_ser_n | output | 1 | Inverse of stage H |

## Verification
On every cycle, assertions check these properties: a load copies the parallel inputs; a shift moves the stages exactly one place and takes the serial bit into stage A; contents are held when no edge is seen; the edge pulse never lasts two cycles; and a clock input held high suppresses edges. The bench scenarios are needed for the rest. They show the end-to-end order of the bits at the output after a load and after a serial fill, through each clock input and through both at once. They also show that one long clock pulse gives a single shift, and that an edge raised during a load leaves no shift behind once the load ends.

// File: rtl/dcsr_pkg.sv
package dcsr_pkg;
  localparam int unsigned STAGES = 8;
  localparam int unsigned NCLK   = 2;

  typedef enum logic {
    MODE_LOAD  = 1'b0,
    MODE_SHIFT = 1'b1
  } mode_e;
endpackage

// File: rtl/dcsr_edge.sv
module dcsr_edge #(
  parameter int unsigned NCLK = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCLK-1:0] clk_in,
  output logic            rise
);
  logic [NCLK-1:0] clk_r;
  logic            comb_d;
  logic            comb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_r  <= '0;
      comb_d <= 1'b0;
    end else begin
      clk_r  <= clk_in;
      comb_d <= comb;
    end
  end

  assign comb = |clk_r;
  assign rise = comb & ~comb_d;

  // R8: an edge pulse never lasts two cycles
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

  // R5: an input held high for two samples blocks any edge
  for (genvar k = 0; k < NCLK; k++) begin : g_inh
    a_r5_held_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_r[k] && $past(clk_r[k])) |-> !rise);
  end
endmodule

// File: rtl/dcsr_stages.sv
module dcsr_stages #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic             shift_en,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] stg_q
);
  logic [WIDTH-1:0] shift_src;

  assign shift_src = {stg_q[WIDTH-2:0], ser_in};

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n)        stg_q[i] <= 1'b0;
      else if (load_en)  stg_q[i] <= par_in[i];
      else if (shift_en) stg_q[i] <= shift_src[i];
    end
  end

  // R1: load copies the parallel word
  a_r1_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (stg_q == $past(par_in)));

  // R4: shift moves one place, serial bit into stage A
  a_r4_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && shift_en) |=>
      (stg_q == {$past(stg_q[WIDTH-2:0]), $past(ser_in)}));

  // R6: nothing changes without load or shift
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !shift_en) |=> $stable(stg_q));
endmodule

// File: rtl/dual_clk_shreg.sv
module dual_clk_shreg
  import dcsr_pkg::*;
#(
  parameter int unsigned WIDTH = STAGES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_load_n,
  input  logic             clk_a,
  input  logic             clk_b,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic             q_ser,
  output logic             q_ser_n
);
  localparam int unsigned LAST = WIDTH - 1;

  mode_e            mode;
  logic             rise;
  logic             load_en;
  logic             shift_en;
  logic [WIDTH-1:0] stg_q;

  assign mode     = mode_e'(shift_load_n);
  assign load_en  = (mode == MODE_LOAD);
  assign shift_en = (mode == MODE_SHIFT) && rise;

  dcsr_edge #(.NCLK(NCLK)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .clk_in ({clk_b, clk_a}),
    .rise   (rise)
  );

  dcsr_stages #(.WIDTH(WIDTH)) u_stages (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_en),
    .shift_en (shift_en),
    .ser_in   (ser_in),
    .par_in   (par_in),
    .stg_q    (stg_q)
  );

  assign q_ser   = stg_q[LAST];
  assign q_ser_n = ~stg_q[LAST];

  // R10: reset clears the output stage
  a_r10_reset: assert property (@(posedge clk)
    !rst_n |=> (!q_ser && q_ser_n));

  // R7: the two outputs always differ
  a_r7_complement: assert property (@(posedge clk) disable iff (!rst_n)
    q_ser != q_ser_n);
endmodule

// File: tb/sim_dual_clk_shreg.sv
module sim_dual_clk_shreg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       shift_load_n = 1'b1;
  logic       clk_a = 1'b0;
  logic       clk_b = 1'b0;
  logic       ser_in = 1'b0;
  logic [7:0] par_in = 8'h00;
  logic       q_ser;
  logic       q_ser_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  dual_clk_shreg u0 (
    .clk(clk), .rst_n(rst_n), .shift_load_n(shift_load_n),
    .clk_a(clk_a), .clk_b(clk_b), .ser_in(ser_in), .par_in(par_in),
    .q_ser(q_ser), .q_ser_n(q_ser_n)
  );

  // {clock select (0=a,1=b,2=both), parallel word, serial bits (bit0 first)}
  localparam logic [17:0] VEC [6] = '{
    {2'd0, 8'hA5, 8'h3C},
    {2'd1, 8'h5A, 8'hC3},
    {2'd0, 8'hFF, 8'h00},
    {2'd1, 8'h00, 8'hFF},
    {2'd2, 8'h81, 8'h7E},
    {2'd0, 8'h96, 8'h01}
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if ({q_ser, q_ser_n} !== {act, ~act} || act !== exp) begin
      n_bad++;
      $display("FAIL %s: got q=%b qn=%b expected q=%b qn=%b",
               req, q_ser, q_ser_n, exp, ~exp);
    end
  endtask

  task automatic do_load(input logic [7:0] v);
    @(negedge clk);
    shift_load_n = 1'b0;
    par_in = v;
    repeat (2) @(negedge clk);
    shift_load_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_shift(input logic [1:0] sel, input logic sin, input int hi);
    @(negedge clk);
    ser_in = sin;
    if (sel != 2'd1) clk_a = 1'b1;
    if (sel != 2'd0) clk_b = 1'b1;
    repeat (hi) @(negedge clk);
    clk_a = 1'b0;
    clk_b = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10", q_ser, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R1 load then R2/R3 shifts, R4 order, R7 outputs
    foreach (VEC[v]) begin
      logic [1:0] sel;
      logic [7:0] pw;
      logic [7:0] sw;
      string tag;
      {sel, pw, sw} = VEC[v];
      tag = (sel == 2'd0) ? "R2 R4 R7" : (sel == 2'd1) ? "R3 R4 R7" : "R8 R4 R7";
      do_load(pw);
      for (int i = 0; i < 8; i++) begin
        check((i == 0) ? "R1" : tag, q_ser, pw[7-i]);
        do_shift(sel, sw[i], 3);
      end
      for (int j = 0; j < 8; j++) begin
        check(tag, q_ser, sw[j]);
        do_shift(sel, 1'b0, 3);
      end
    end

    // R1: load follows par_in every cycle
    @(negedge clk);
    shift_load_n = 1'b0;
    par_in = 8'h80;
    @(negedge clk);
    check("R1", q_ser, 1'b1);
    par_in = 8'h00;
    @(negedge clk);
    check("R1", q_ser, 1'b0);

    // R9: edge raised during load, clk_b kept high
    par_in = 8'h80;
    clk_b = 1'b1;
    repeat (4) @(negedge clk);
    shift_load_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9", q_ser, 1'b1);

    // R5: clk_b held high, clk_a toggles, then clk_b released
    for (int t = 0; t < 3; t++) begin
      clk_a = 1'b1;
      repeat (3) @(negedge clk);
      clk_a = 1'b0;
      repeat (2) @(negedge clk);
    end
    check("R5", q_ser, 1'b1);
    clk_b = 1'b0;
    repeat (3) @(negedge clk);
    check("R5", q_ser, 1'b1);

    // R5: symmetric case, clk_a held high
    clk_a = 1'b1;
    repeat (3) @(negedge clk);
    do_load(8'h80);
    for (int t = 0; t < 3; t++) begin
      clk_b = 1'b1;
      repeat (3) @(negedge clk);
      clk_b = 1'b0;
      repeat (2) @(negedge clk);
    end
    check("R5", q_ser, 1'b1);
    clk_a = 1'b0;
    repeat (3) @(negedge clk);
    check("R5", q_ser, 1'b1);

    // R6: no edges, inputs wiggle, contents held
    for (int t = 0; t < 20; t++) begin
      par_in = 8'(t * 37);
      ser_in = t[0];
      @(negedge clk);
    end
    check("R6", q_ser, 1'b1);

    // R2 timing: not shifted after one edge, shifted after two
    do_load(8'h40);
    ser_in = 1'b0;
    clk_a = 1'b1;
    @(negedge clk);
    check("R2", q_ser, 1'b0);
    @(negedge clk);
    check("R2", q_ser, 1'b1);
    // R8: long high time gives a single shift
    repeat (50) @(negedge clk);
    check("R8", q_ser, 1'b1);
    clk_a = 1'b0;
    repeat (2) @(negedge clk);

    // R8: both inputs rising together give one shift
    do_load(8'h40);
    do_shift(2'd2, 1'b0, 3);
    check("R8", q_ser, 1'b1);

    // R10: reset in mid-use clears the register
    do_load(8'hFF);
    rst_n = 1'b0;
    @(negedge clk);
    check("R10", q_ser, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    finish_run();
  end
endmodule